// File: doc/BRIEF.md
# Push-Pull Primary Drive Generator

This block turns one crystal-rate clock into the two alternating gate-drive signals for the primary switches of a push-pull resonant converter. A modulo-20 prescaler feeds a toggle stage. The result is a switching period of 40 input clocks, about 89.49 kHz from a 3.579545 MHz clock. Each gate is high for one 20-clock half of the period, and the two gates are never high together.

Two asynchronous control inputs each pass through a two-flop synchronizer before use. The first is an active-high enable. The second is an over-current flag from an external comparator. A low enable holds both gates off. A synchronized over-current flag forces both gates off at once. The block then keeps the gates blanked for the rest of that switching period. It releases them at the next period boundary, but only if the flag is low by then. This gives cycle-by-cycle current limiting, not a latched shutdown.

For downstream sampling logic, the block outputs a phase indicator and a one-clock reference strobe. The strobe fires where the second gate's half-period begins. Both come from the free-running divider, so neither depends on enable or over-current.

Top module: `pp_drive_gen`

## Requirements
- R1: Counting from the first rising clock edge after reset release as position 0, the switching period is 40 clocks. With enable active and no over-current, `gate_a` is high at positions 0–19 and `gate_b` is high at positions 20–39.
- R2: `gate_a` and `gate_b` are never high in the same cycle.
- R3: With enable active and no over-current, each gate stays high for exactly 20 consecutive clocks in every period.
- R4: `enable_in` passes through two flops. Both gates are low from the second rising edge after `enable_in` falls. They follow R1 again from the second rising edge after it rises.
- R5: `ocp_in` passes through two flops. Both gates are low from the second rising edge after `ocp_in` rises.
- R6: After a synchronized over-current, both gates stay low until the next position 0. They are released there only if the synchronized flag is low on the edge that enters position 0. Otherwise blanking lasts another full period.
- R7: `ref_strobe` is high for exactly one clock, at position 20 of every period, whatever the state of enable and over-current.
- R8: `phase_b` is 0 at positions 0–19 and 1 at positions 20–39.
- R9: While `rst_n` is low, `gate_a`, `gate_b`, `ref_strobe` and `phase_b` are all 0. The divider restarts at position 0 when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_in | input | 1 | Asynchronous active-high run enable |
| ocp_in | input | 1 | Asynchronous over-current flag from external comparator |
| gate_a | output | 1 | First primary gate drive |
| gate_b | output | 1 | Second primary gate drive |
| ref_strobe | output | 1 | One-clock pulse at the start of the `gate_b` half |
| phase_b | output | 1 | High during the `gate_b` half of the period |

## Verification
A vector table drives the gates through several stimulus segments, and a bench model checks every cycle. The segments are:
- a long free run, which separates the correct 40-clock period and 20/20 split from off-by-one dividers;
- short and long enable drops, which expose synchronizer latency errors;
- over-current pulses that end inside a period;
- over-current held across a period boundary.

The last two cases together separate true cycle-by-cycle release from a release that does not wait for the boundary, and from a release that ignores a flag still high at the boundary. Directed tests cover the reset state and a single-clock over-current glitch.

// File: rtl/pp_pkg.sv
package pp_pkg;
   typedef enum logic {HALF_A = 1'b0, HALF_B = 1'b1} half_e;
   localparam int unsigned PP_HALVES = 2;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pp_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pp_sync: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], d_async[b]};
      end
      assign q_sync[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/pp_divider.sv
module pp_divider
   import pp_pkg::*;
#(
   parameter int unsigned DIV_MOD = 20
) (
   input  logic  clk,
   input  logic  rst_n,
   output half_e half,
   output logic  wrap,
   output logic  strobe
);
   localparam int unsigned CW = (DIV_MOD > 1) ? $clog2(DIV_MOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV_MOD - 1);

   if (DIV_MOD < 2) begin : g_bad_mod
      $error("pp_divider: DIV_MOD must be at least 2");
   end

   logic [CW-1:0] cnt;
   logic          at_last;

   assign at_last = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         half <= HALF_A;
      end else if (at_last) begin
         cnt  <= '0;
         half <= (half == HALF_A) ? HALF_B : HALF_A;
      end else begin
         cnt  <= cnt + 1'b1;
      end
   end

   assign wrap   = at_last && (half == HALF_B);
   assign strobe = (cnt == '0) && (half == HALF_B);

   AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      at_last |=> half != $past(half)); // R1
   AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !at_last |=> $stable(half)); // R3
   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      at_last |=> cnt == '0); // R1
endmodule

// File: rtl/pp_blanker.sv
module pp_blanker (
   input  logic clk,
   input  logic rst_n,
   input  logic ocp_s,
   input  logic wrap,
   output logic blank_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      blank_q <= 1'b0;
      else if (ocp_s)  blank_q <= 1'b1;
      else if (wrap)   blank_q <= 1'b0;
   end

   AST_BLANK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ocp_s |=> blank_q); // R5
   AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_q && !wrap) |=> blank_q); // R6
   AST_BLANK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !ocp_s) |=> !blank_q); // R6
endmodule

// File: rtl/pp_drive_gen.sv
module pp_drive_gen
   import pp_pkg::*;
#(
   parameter int unsigned DIV_MOD     = 20,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable_in,
   input  logic ocp_in,
   output logic gate_a,
   output logic gate_b,
   output logic ref_strobe,
   output logic phase_b
);
   localparam int unsigned N_CTRL = 2;

   logic [N_CTRL-1:0] ctrl_s;
   logic              en_s;
   logic              ocp_s;
   half_e             half;
   logic              wrap;
   logic              blank_q;
   logic              run;

   pp_sync #(.WIDTH(N_CTRL), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({ocp_in, enable_in}),
      .q_sync  (ctrl_s)
   );
   assign en_s  = ctrl_s[0];
   assign ocp_s = ctrl_s[1];

   pp_divider #(.DIV_MOD(DIV_MOD)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .half   (half),
      .wrap   (wrap),
      .strobe (ref_strobe)
   );

   pp_blanker u_blank (
      .clk     (clk),
      .rst_n   (rst_n),
      .ocp_s   (ocp_s),
      .wrap    (wrap),
      .blank_q (blank_q)
   );

   assign run     = en_s && !ocp_s && !blank_q;
   assign gate_a  = run && (half == HALF_A);
   assign gate_b  = run && (half == HALF_B);
   assign phase_b = (half == HALF_B);

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_a && gate_b)); // R2
   AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |-> !gate_a && !gate_b); // R4
   AST_OCP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ocp_s |-> !gate_a && !gate_b); // R5
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ref_strobe |=> !ref_strobe); // R7
   AST_STROBE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      ref_strobe |-> phase_b && $rose(phase_b)); // R8
endmodule

// File: tb/pp_drive_gen_test.sv
module pp_drive_gen_test;
   localparam int CLK_PERIOD = 10;
   localparam int PERIOD     = 40;
   localparam int HALF       = 20;
   localparam int NVEC       = 10;
   // each entry: {enable, ocp, cycles[7:0]}
   localparam logic [9:0] VEC [NVEC] = '{
      {1'b1, 1'b0, 8'd95},
      {1'b0, 1'b0, 8'd7},
      {1'b1, 1'b0, 8'd50},
      {1'b1, 1'b1, 8'd3},
      {1'b1, 1'b0, 8'd60},
      {1'b1, 1'b1, 8'd55},
      {1'b1, 1'b0, 8'd45},
      {1'b0, 1'b1, 8'd30},
      {1'b1, 1'b0, 8'd33},
      {1'b0, 1'b0, 8'd90}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable_in = 1'b0;
   logic ocp_in = 1'b0;
   logic gate_a, gate_b, ref_strobe, phase_b;

   int checks = 0;
   int errors = 0;
   bit scoreboard_on = 1'b0;
   bit done = 1'b0;

   // requirement-level model state
   int  k = 0;
   bit  e1, e2, o1, o2, blk;

   always #(CLK_PERIOD/2) clk = ~clk;

   pp_drive_gen uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable_in  (enable_in),
      .ocp_in     (ocp_in),
      .gate_a     (gate_a),
      .gate_b     (gate_b),
      .ref_strobe (ref_strobe),
      .phase_b    (phase_b)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k <= 0; e1 <= 0; e2 <= 0; o1 <= 0; o2 <= 0; blk <= 0;
      end else begin
         k  <= k + 1;
         e1 <= enable_in; e2 <= e1;
         o1 <= ocp_in;    o2 <= o1;
         if (o2) blk <= 1'b1;
         else if ((k % PERIOD) == PERIOD - 1) blk <= 1'b0;
      end
   end

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at t=%0t pos=%0d: actual %0b expected %0b",
                  tag, $time, k % PERIOD, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (scoreboard_on && rst_n) begin
         int  pos;
         bit  run;
         string tag;
         pos = k % PERIOD;
         run = e2 && !o2 && !blk;
         if (!e2)      tag = "R4 gate off while disabled";
         else if (o2)  tag = "R5 gate off on over-current";
         else if (blk) tag = "R6 blanking held to period start";
         else          tag = "R1/R3 gate half-period";
         check({tag, " gate_a"}, gate_a, run && pos < HALF);
         check({tag, " gate_b"}, gate_b, run && pos >= HALF);
         check("R2 no overlap", gate_a && gate_b, 1'b0);
         check("R7 ref_strobe", ref_strobe, pos == HALF);
         check("R8 phase_b", phase_b, pos >= HALF);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      enable_in = 1'b1;
      repeat (5) @(negedge clk);
      check("R9 reset gate_a", gate_a, 1'b0);
      check("R9 reset gate_b", gate_b, 1'b0);
      check("R9 reset ref_strobe", ref_strobe, 1'b0);
      check("R9 reset phase_b", phase_b, 1'b0);
      rst_n = 1'b1;
      scoreboard_on = 1'b1;

      foreach (VEC[i]) begin
         enable_in = VEC[i][9];
         ocp_in    = VEC[i][8];
         repeat (int'(VEC[i][7:0])) @(negedge clk);
      end

      // R6: one-clock over-current glitch early in a period
      enable_in = 1'b1;
      ocp_in    = 1'b0;
      while ((k % PERIOD) != 3) @(negedge clk);
      ocp_in = 1'b1;
      @(negedge clk);
      ocp_in = 1'b0;
      @(negedge clk);
      check("R5 glitch blanks gate_a", gate_a, 1'b0);
      while ((k % PERIOD) != PERIOD - 1) @(negedge clk);
      check("R6 still blanked at pos 39", gate_b, 1'b0);
      @(negedge clk);
      check("R6 released at pos 0", gate_a, 1'b1);

      // R9: reset mid-period restarts divider at position 0
      while ((k % PERIOD) != 27) @(negedge clk);
      scoreboard_on = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check("R9 gate_b low in reset", gate_b, 1'b0);
      check("R9 phase_b low in reset", phase_b, 1'b0);
      rst_n = 1'b1;
      scoreboard_on = 1'b1;
      repeat (3) @(negedge clk);
      check("R9 restart phase_b at pos 3", phase_b, 1'b0);
      check("R9 restart gate_a at pos 3", gate_a, 1'b1);
      repeat (HALF - 3) @(negedge clk);
      check("R7 strobe after restart", ref_strobe, 1'b1);
      repeat (2 * PERIOD) @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule